// File: doc/BRIEF.md
# Display RAM Write Address Generator

This block holds the column pointer and the bank pointer used to write a graphic LCD controller's display data RAM. A host decoder gives it strobes that load the column or the bank, a strobe that loads the order bit, and a data strobe carrying one byte. Each data byte becomes a one-cycle RAM write at the current bank and column. The pointers then step to the next cell.

The order bit selects between two walks. In horizontal order the column steps and carries into the bank. In vertical order the bank steps across the pixel banks and carries into the column. The bank just past the last pixel bank holds icon data. Writes there always walk horizontally and stay in that bank, whatever the order bit says. With default parameters the columns are 0..127, pixel banks are 0..4 and the icon bank is 5.

Top module: `lcd_ram_addr_gen`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) sets the column to 0, the bank to 0 and the order bit to horizontal (0), and it holds ram_we low.
- R2: A column load strobe stores the 7-bit column value, and the next write goes to that column.
- R3: A bank load strobe with a value from 0 to 5 stores that bank. Values 6 and 7 are ignored, and the previous bank is kept.
- R4: A data strobe at one clock edge makes ram_we high for exactly the following cycle. In that cycle ram_addr = bank*128 + column (bank in bits 9:7, column in bits 6:0), taken before the pointers advance, and ram_wdata carries the byte.
- R5: With the order bit at 0 and a pixel bank selected, each write raises the column by one and leaves the bank unchanged, unless the column is 127.
- R6: In horizontal order a write at column 127 wraps the column to 0 and moves to the next pixel bank. Bank 4 wraps to bank 0.
- R7: With the order bit at 1 and a pixel bank selected, each write below bank 4 raises the bank by one and leaves the column unchanged.
- R8: In vertical order a write at bank 4 wraps the bank to 0 and raises the column by one. Column 127 wraps to 0.
- R9: While the icon bank (5) is selected, writes walk horizontally whatever the order bit is. Column 127 wraps to 0 and the bank stays 5.
- R10: An order strobe loads the order bit (0 = horizontal, 1 = vertical), and it applies from the next write onward.
- R11: When a load strobe comes in the same cycle as a data strobe, the write uses the pointers held before that edge. The loaded value replaces the step of that pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| col_ld | input | 1 | Load the column pointer |
| col_ld_val | input | 7 | Column value to load |
| bank_ld | input | 1 | Load the bank pointer |
| bank_ld_val | input | 3 | Bank value to load (6 and 7 are ignored) |
| order_ld | input | 1 | Load the order bit |
| order_vert | input | 1 | Order value: 0 horizontal, 1 vertical |
| wr_stb | input | 1 | Data byte strobe |
| wr_byte | input | 8 | Data byte |
| ram_we | output | 1 | Display RAM write enable, one cycle per byte |
| ram_addr | output | 10 | Display RAM address {bank, column} |
| ram_wdata | output | 8 | Display RAM write data |

## Verification
Every result appears one clock after its strobe. The RAM write and its address show in the cycle after the data strobe. The pointer step, a load or the order bit can be seen only through the address of the next write. The bench drives each strobe for one cycle at a falling edge and samples the write outputs at the next falling edge, one rising edge later. It checks loaded or stepped pointers through a later write, and checks that ram_we is low again one cycle after that. Expected addresses come from a linear cell index: bank*128+column in horizontal order, column*5+bank in vertical order, and column modulo 128 in the icon bank. This is worked out apart from the carry structure of the design.

// File: rtl/lcd_addr_pkg.sv
package lcd_addr_pkg;

   typedef enum logic {
      ORDER_HORIZ = 1'b0,
      ORDER_VERT  = 1'b1
   } order_e;

   typedef struct packed {
      logic col_step;
      logic bank_step;
   } step_t;

endpackage

// File: rtl/lcd_wrap_ctr.sv
// Wrapping pointer with a range-checked load.
// A load is taken only when the value does not exceed LOAD_MAX.
// A step at LAST returns the pointer to 0.
module lcd_wrap_ctr #(
   parameter int W        = 7,
   parameter int LAST     = 127,
   parameter int LOAD_MAX = 127
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   input  logic         step,
   output logic [W-1:0] q,
   output logic         at_last
);

   localparam logic [W-1:0] LAST_V = W'(LAST);
   localparam logic [W-1:0] ONE_V  = W'(1);

   initial begin
      if (LAST < 0 || LAST >= (1 << W))
         $error("lcd_wrap_ctr: LAST outside pointer range");
      if (LOAD_MAX < LAST)
         $error("lcd_wrap_ctr: LOAD_MAX below LAST");
   end

   logic ld_ok;

   generate
      if (LOAD_MAX >= (1 << W) - 1) begin : g_load_any
         assign ld_ok = ld;
      end else begin : g_load_limited
         localparam logic [W-1:0] LMAX_V = W'(LOAD_MAX);
         assign ld_ok = ld && (ld_val <= LMAX_V);
      end
   endgenerate

   assign at_last = (q == LAST_V);

   always_ff @(posedge clk) begin
      if (rst) begin
         q <= '0;
      end else if (ld_ok) begin
         q <= ld_val;
      end else if (step) begin
         q <= at_last ? '0 : q + ONE_V;
      end
   end

endmodule

// File: rtl/lcd_addr_seq.sv
// Decides which pointer steps on a write, from the order and the carry flags.
module lcd_addr_seq
   import lcd_addr_pkg::*;
(
   input  logic wr,
   input  logic order_vert,
   input  logic col_last,
   input  logic bank_last,
   input  logic bank_icon,
   output logic col_step,
   output logic bank_step
);

   order_e ord;
   step_t  st;

   always_comb begin
      ord = (order_vert && !bank_icon) ? ORDER_VERT : ORDER_HORIZ;
      st  = '0;
      if (wr) begin
         unique case (ord)
            ORDER_HORIZ: begin
               st.col_step  = 1'b1;
               st.bank_step = col_last && !bank_icon;
            end
            ORDER_VERT: begin
               st.bank_step = 1'b1;
               st.col_step  = bank_last;
            end
            default: st = '0;
         endcase
      end
   end

   assign col_step  = st.col_step;
   assign bank_step = st.bank_step;

endmodule

// File: rtl/lcd_wr_port.sv
// Output register for the display RAM write.
module lcd_wr_port #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] data_in,
   output logic              we,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] data
);

   always_ff @(posedge clk) begin
      if (rst) begin
         we   <= 1'b0;
         addr <= '0;
         data <= '0;
      end else begin
         we <= wr;
         if (wr) begin
            addr <= addr_in;
            data <= data_in;
         end
      end
   end

endmodule

// File: rtl/lcd_ram_addr_gen.sv
module lcd_ram_addr_gen #(
   parameter int COL_W     = 7,
   parameter int BANK_W    = 3,
   parameter int PIX_BANKS = 5,
   parameter int ICON_BANK = 5,
   parameter int DATA_W    = 8,
   localparam int ADDR_W   = BANK_W + COL_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              col_ld,
   input  logic [COL_W-1:0]  col_ld_val,
   input  logic              bank_ld,
   input  logic [BANK_W-1:0] bank_ld_val,
   input  logic              order_ld,
   input  logic              order_vert,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_byte,
   output logic              ram_we,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [DATA_W-1:0] ram_wdata
);

   localparam int COL_LAST  = (1 << COL_W) - 1;
   localparam int BANK_LAST = PIX_BANKS - 1;
   localparam logic [BANK_W-1:0] ICON_V = BANK_W'(ICON_BANK);

   initial begin
      if (PIX_BANKS < 1)
         $error("lcd_ram_addr_gen: need at least one pixel bank");
      if (ICON_BANK != PIX_BANKS)
         $error("lcd_ram_addr_gen: icon bank must follow the last pixel bank");
      if (ICON_BANK >= (1 << BANK_W))
         $error("lcd_ram_addr_gen: icon bank does not fit the bank field");
   end

   logic [COL_W-1:0]  col_q;
   logic [BANK_W-1:0] bank_q;
   logic              order_q;
   logic              col_last, bank_last, bank_icon;
   logic              col_step, bank_step;

   always_ff @(posedge clk) begin
      if (rst)           order_q <= 1'b0;
      else if (order_ld) order_q <= order_vert;
   end

   assign bank_icon = (bank_q == ICON_V);

   lcd_wrap_ctr #(
      .W(COL_W), .LAST(COL_LAST), .LOAD_MAX(COL_LAST)
   ) u_col (
      .clk(clk), .rst(rst), .ld(col_ld), .ld_val(col_ld_val),
      .step(col_step), .q(col_q), .at_last(col_last)
   );

   lcd_wrap_ctr #(
      .W(BANK_W), .LAST(BANK_LAST), .LOAD_MAX(ICON_BANK)
   ) u_bank (
      .clk(clk), .rst(rst), .ld(bank_ld), .ld_val(bank_ld_val),
      .step(bank_step), .q(bank_q), .at_last(bank_last)
   );

   lcd_addr_seq u_seq (
      .wr(wr_stb), .order_vert(order_q), .col_last(col_last),
      .bank_last(bank_last), .bank_icon(bank_icon),
      .col_step(col_step), .bank_step(bank_step)
   );

   lcd_wr_port #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) u_port (
      .clk(clk), .rst(rst), .wr(wr_stb), .addr_in({bank_q, col_q}),
      .data_in(wr_byte), .we(ram_we), .addr(ram_addr), .data(ram_wdata)
   );

endmodule

// File: rtl/lcd_ram_addr_gen_chk.sv
module lcd_ram_addr_gen_chk #(
   parameter int COL_W     = 7,
   parameter int BANK_W    = 3,
   parameter int PIX_BANKS = 5,
   parameter int ICON_BANK = 5
) (
   input logic                      clk,
   input logic                      rst,
   input logic                      wr_stb,
   input logic                      col_ld,
   input logic                      bank_ld,
   input logic [BANK_W-1:0]         bank_ld_val,
   input logic [COL_W-1:0]          col,
   input logic [BANK_W-1:0]         bank,
   input logic                      order,
   input logic                      ram_we,
   input logic [BANK_W+COL_W-1:0]   ram_addr
);

   localparam logic [COL_W-1:0]  COL_MAX = {COL_W{1'b1}};
   localparam logic [BANK_W-1:0] ICON_V  = BANK_W'(ICON_BANK);
   localparam logic [BANK_W-1:0] BLAST_V = BANK_W'(PIX_BANKS - 1);

   logic no_ld;
   assign no_ld = !col_ld && !bank_ld;

   // R4
   a_r4_we_after_stb: assert property (@(posedge clk) disable iff (rst)
      wr_stb |=> ram_we);
   a_r4_we_single: assert property (@(posedge clk) disable iff (rst)
      !wr_stb |=> !ram_we);
   a_r4_addr_before_step: assert property (@(posedge clk) disable iff (rst)
      wr_stb |=> ram_addr == {$past(bank), $past(col)});
   // R3
   a_r3_bank_in_range: assert property (@(posedge clk) disable iff (rst)
      bank <= ICON_V);
   a_r3_bad_bank_ignored: assert property (@(posedge clk) disable iff (rst)
      bank_ld && bank_ld_val > ICON_V && !wr_stb |=> $stable(bank));
   // R5
   a_r5_horiz_step: assert property (@(posedge clk) disable iff (rst)
      wr_stb && no_ld && !order && col != COL_MAX
      |=> col == COL_W'($past(col) + 1'b1) && $stable(bank));
   // R7
   a_r7_vert_step: assert property (@(posedge clk) disable iff (rst)
      wr_stb && no_ld && order && bank < BLAST_V
      |=> bank == BANK_W'($past(bank) + 1'b1) && $stable(col));
   // R9
   a_r9_icon_stays: assert property (@(posedge clk) disable iff (rst)
      wr_stb && !bank_ld && bank == ICON_V |=> bank == ICON_V);

endmodule

bind lcd_ram_addr_gen lcd_ram_addr_gen_chk #(
   .COL_W(COL_W), .BANK_W(BANK_W), .PIX_BANKS(PIX_BANKS), .ICON_BANK(ICON_BANK)
) u_chk (
   .clk(clk), .rst(rst), .wr_stb(wr_stb), .col_ld(col_ld), .bank_ld(bank_ld),
   .bank_ld_val(bank_ld_val), .col(col_q), .bank(bank_q), .order(order_q),
   .ram_we(ram_we), .ram_addr(ram_addr)
);

// File: tb/lcd_ram_addr_gen_bench.sv
module lcd_ram_addr_gen_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NCOL  = 128;
   localparam int NPIX  = 5;
   localparam int ICON  = 5;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       col_ld = 1'b0;
   logic [6:0] col_ld_val = '0;
   logic       bank_ld = 1'b0;
   logic [2:0] bank_ld_val = '0;
   logic       order_ld = 1'b0;
   logic       order_vert = 1'b0;
   logic       wr_stb = 1'b0;
   logic [7:0] wr_byte = '0;
   logic       ram_we;
   logic [9:0] ram_addr;
   logic [7:0] ram_wdata;

   int n_chk = 0;
   int n_err = 0;
   int mx = 0, my = 0, mv = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lcd_ram_addr_gen u_lcd_ram_addr_gen (
      .clk(clk), .rst(rst), .col_ld(col_ld), .col_ld_val(col_ld_val),
      .bank_ld(bank_ld), .bank_ld_val(bank_ld_val), .order_ld(order_ld),
      .order_vert(order_vert), .wr_stb(wr_stb), .wr_byte(wr_byte),
      .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic void model_step();
      int lin;
      if (my == ICON) begin
         mx = (mx + 1) % NCOL;
      end else if (mv == 0) begin
         lin = (my * NCOL + mx + 1) % (NCOL * NPIX);
         my = lin / NCOL;  mx = lin % NCOL;
      end else begin
         lin = (mx * NPIX + my + 1) % (NCOL * NPIX);
         mx = lin / NPIX;  my = lin % NPIX;
      end
   endfunction

   task automatic do_write(input string req, input logic [7:0] d);
      @(negedge clk);
      wr_stb = 1'b1; wr_byte = d;
      @(negedge clk);
      wr_stb = 1'b0;
      check({req, " R4 we"}, int'(ram_we), 1);
      check({req, " addr"}, int'(ram_addr), my * NCOL + mx);
      check({req, " R4 data"}, int'(ram_wdata), int'(d));
      model_step();
   endtask

   task automatic idle_check();
      @(negedge clk);
      check("R4 we single", int'(ram_we), 0);
   endtask

   task automatic load_col(input int v);
      @(negedge clk); col_ld = 1'b1; col_ld_val = 7'(v);
      @(negedge clk); col_ld = 1'b0;
      mx = v;
   endtask

   task automatic load_bank(input int v);
      @(negedge clk); bank_ld = 1'b1; bank_ld_val = 3'(v);
      @(negedge clk); bank_ld = 1'b0;
      if (v <= ICON) my = v;
   endtask

   task automatic load_order(input int v);
      @(negedge clk); order_ld = 1'b1; order_vert = v[0];
      @(negedge clk); order_ld = 1'b0;
      mv = v;
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      mx = 0; my = 0; mv = 0;
      check("R1 we low", int'(ram_we), 0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      do_reset();
      do_write("R1 reset origin", 8'hA5);
      idle_check();

      // R10 / R1: order bit set, then cleared by reset
      load_order(1);
      do_reset();
      do_write("R1 order cleared", 8'h11);
      do_write("R1 horiz after reset", 8'h12);

      // R5 R6: full horizontal sweep across all pixel banks plus wrap
      load_col(0); load_bank(0);
      for (int i = 0; i < NCOL * NPIX + 3; i++)
         do_write("R5 R6 horiz sweep", 8'(i));
      idle_check();

      // R2: column load values
      for (int c = 0; c < NCOL; c += 37) begin
         load_col(c);
         do_write("R2 col load", 8'(c));
      end

      // R3: every bank value, 6 and 7 ignored
      for (int b = 0; b < 8; b++) begin
         load_bank(2);
         load_bank(b);
         do_write("R3 bank load", 8'(b));
      end

      // R10 R7 R8: full vertical sweep with wrap
      load_order(1);
      load_col(0); load_bank(0);
      for (int i = 0; i < NCOL * NPIX + 2; i++)
         do_write("R7 R8 vert sweep", 8'(255 - (i % 256)));

      // R8: column 127 wraps in vertical order
      load_col(127); load_bank(4);
      do_write("R8 col wrap", 8'h77);
      do_write("R8 after wrap", 8'h78);

      // R9: icon bank walks horizontally under both orders
      load_bank(ICON); load_col(120);
      for (int i = 0; i < 12; i++)
         do_write("R9 icon vert mode", 8'(i));
      load_order(0);
      load_col(126);
      for (int i = 0; i < 4; i++)
         do_write("R9 icon horiz mode", 8'(i));

      // R10: order switch applies to the next write
      load_bank(1); load_col(10);
      do_write("R10 horiz", 8'h21);
      load_order(1);
      do_write("R10 vert", 8'h22);
      do_write("R10 vert2", 8'h23);

      // R11: load in same cycle as write
      load_order(0); load_bank(3); load_col(20);
      @(negedge clk);
      wr_stb = 1'b1; wr_byte = 8'h5C; col_ld = 1'b1; col_ld_val = 7'd40;
      @(negedge clk);
      wr_stb = 1'b0; col_ld = 1'b0;
      check("R11 old addr", int'(ram_addr), 3 * NCOL + 20);
      check("R11 we", int'(ram_we), 1);
      mx = 40;
      do_write("R11 col load wins", 8'h5D);
      @(negedge clk);
      wr_stb = 1'b1; wr_byte = 8'h5E; bank_ld = 1'b1; bank_ld_val = 3'd0;
      @(negedge clk);
      wr_stb = 1'b0; bank_ld = 1'b0;
      check("R11 old bank addr", int'(ram_addr), 3 * NCOL + 41);
      mx = 42; my = 0;
      do_write("R11 bank load wins", 8'h5F);
      idle_check();

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule